// File: doc/BRIEF.md
# Serial Bootstrap Loader Sequencer

This block runs the serial start-up handshake of a chip that can be loaded over a plain asynchronous serial link. A strap input is sampled while reset is held. If the strap was low, the block waits, with no time limit, for the host to send a byte of value zero. The block times the low stretch of that byte (start bit plus eight zero data bits) to work out the bit period. It then enables the transmit driver and sends back one identification byte.

After the identification byte has been sent, including its stop bit, the block enables its receiver. It takes in exactly 32 payload bytes and hands each one to a buffer through a write port. When the last byte has been accepted it raises a completion pulse. Only one direction of the link is active at any time, so a half-duplex connection is enough.

The write port is valid/ready. `wr_valid` rises when a byte has been received. `wr_data` and `wr_addr` then stay frozen until a cycle in which `wr_ready` is high, and that cycle transfers the byte. The serial source cannot be paused. The buffer must therefore accept each byte before the next one finishes arriving, about ten bit periods later. If it does not, the newer byte is lost and the error flag is set.

Top module: `boot_serial_loader`

## Requirements
- R1: The strap level is captured only while `rst_n` is low. If the captured level was high, then after reset `tx_oe` stays 0, `txd` stays 1 and no write happens, whatever arrives on `rxd`. Changing the strap after reset has no effect.
- R2: In loader mode, a zero byte whose low stretch lasts 9·P clocks sets the bit period to P. The block then sends `id_code` on `txd` in 8N1 format: a low start bit, data LSB first, then a high stop bit, each bit lasting P clocks.
- R3: A low stretch on `rxd` that yields a period below MIN_PER clocks (4 by default) is discarded. The block goes on waiting for a zero byte and sends nothing.
- R4: `txd` is 1 whenever `tx_oe` is 0. `tx_oe` goes to 1 when the period is locked and stays at 1 until reset.
- R5: The receiver is off until the stop bit of the identification byte has ended. Activity on `rxd` during the identification byte produces no write.
- R6: Received payload bytes appear on `wr_data` in arrival order, with `wr_addr` counting 0, 1, … 31. Each byte is sampled at mid-bit in 8N1 format, LSB first.
- R7: While `wr_valid` is 1 and `wr_ready` is 0, `wr_valid`, `wr_data` and `wr_addr` hold their values.
- R8: `done` is high for exactly one clock: the cycle after the transfer at address 31. It is raised once only, and further traffic on `rxd` causes no write.
- R9: A byte whose stop bit samples low sets `link_err`, and the byte is still delivered. `link_err` stays set until reset.
- R10: If a byte finishes arriving while the previous byte is still waiting on the write port, the new byte is dropped and `link_err` is set. The waiting byte is kept.
- R11: Nothing times out. The zero byte may arrive after any idle time and is still handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; the strap is captured while it is low |
| boot_strap_n | input | 1 | Mode strap; low during reset selects loader mode |
| rxd | input | 1 | Serial receive line, idles high |
| id_code | input | 8 | Identification byte to send back to the host |
| txd | output | 1 | Serial transmit line, idles high |
| tx_oe | output | 1 | Output enable for the transmit pin |
| wr_valid | output | 1 | A payload byte is waiting on the write port |
| wr_ready | input | 1 | The buffer accepts the waiting byte this cycle |
| wr_addr | output | 5 | Buffer address of the waiting byte, 0 to 31 |
| wr_data | output | 8 | Waiting payload byte |
| done | output | 1 | One-clock pulse after the last payload byte has been accepted |
| link_err | output | 1 | Sticky flag for a framing error or a lost byte |

## Verification
Two situations are hard to reach from the ports.

The first is a lost byte. It needs the buffer to withhold `wr_ready` for more than a whole byte time, so the bench holds ready low across two complete serial frames. It then checks that the first byte is still offered unchanged and that the error flag has been set.

The second is line activity while the identification byte is being sent. To cover it, the bench drives a three-bit-long low pulse on `rxd` inside the identification window. The scoreboard then sees that the payload still starts at address 0.

A short low glitch that comes before the real zero byte checks that too fast a rate is rejected.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

  typedef enum logic [2:0] {
    ST_ARM,
    ST_OFF,
    ST_MEASURE,
    ST_IDENT,
    ST_LOAD,
    ST_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;

  // bits per serial character payload
  localparam int unsigned CHAR_BITS = 8;
  // low bits in the calibration byte: start bit plus eight zero data bits
  localparam int unsigned CAL_LOW_BITS = 9;

endpackage

// File: rtl/bsl_rx_sync.sv
module bsl_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_s,
  output logic rx_fall,
  output logic rx_rise
);
  logic [STAGES-1:0] pipe;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= rx_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2:0], rx_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= pipe[STAGES-1];
  end

  assign rx_s    = pipe[STAGES-1];
  assign rx_fall = prev & ~rx_s;
  assign rx_rise = ~prev & rx_s;

endmodule

// File: rtl/bsl_baud_meter.sv
module bsl_baud_meter
  import bsl_pkg::*;
#(
  parameter int unsigned PER_W   = 16,
  parameter int unsigned MIN_PER = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rx_s,
  input  logic             rx_fall,
  input  logic             rx_rise,
  output logic             per_valid,
  output logic [PER_W-1:0] per
);
  localparam int unsigned SUB_W = $clog2(CAL_LOW_BITS);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CAL_LOW_BITS - 1);

  logic             busy;
  logic [SUB_W-1:0] sub;
  logic [PER_W-1:0] quo;

  // quotient of low-cycle count by nine, built up as the cycles pass
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      sub       <= '0;
      quo       <= '0;
      per_valid <= 1'b0;
      per       <= '0;
    end else begin
      per_valid <= 1'b0;
      if (!en) begin
        busy <= 1'b0;
      end else if (!busy) begin
        if (rx_fall) begin
          busy <= 1'b1;
          sub  <= SUB_W'(1);
          quo  <= '0;
        end
      end else if (rx_rise) begin
        busy <= 1'b0;
        if (quo >= PER_W'(MIN_PER)) begin
          per_valid <= 1'b1;
          per       <= quo;
        end
      end else if (!rx_s) begin
        if (sub == SUB_LAST) begin
          sub <= '0;
          if (quo != '1) quo <= quo + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  AST_PER_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> (per >= PER_W'(MIN_PER))); // R3

  AST_LOCK_AFTER_MEASURE: assert property (@(posedge clk) disable iff (!rst_n)
    per_valid |-> $past(busy)); // R2

endmodule

// File: rtl/bsl_uart_tx.sv
module bsl_uart_tx
  import bsl_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [CHAR_BITS-1:0] data,
  input  logic [PER_W-1:0]     per,
  output logic                 txd,
  output logic                 busy,
  output logic                 fin
);
  localparam int unsigned BIT_W = $clog2(CHAR_BITS + 2);
  localparam logic [BIT_W-1:0] STOP_IDX = BIT_W'(CHAR_BITS + 1);

  logic [CHAR_BITS:0] shreg;
  logic [BIT_W-1:0]   bitn;
  logic [PER_W-1:0]   cnt;
  logic [PER_W-1:0]   per_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd   <= 1'b1;
      busy  <= 1'b0;
      fin   <= 1'b0;
      shreg <= '1;
      bitn  <= '0;
      cnt   <= '0;
      per_q <= '0;
    end else begin
      fin <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          txd   <= 1'b0;
          shreg <= {1'b1, data};
          bitn  <= '0;
          per_q <= per;
          cnt   <= per - 1'b1;
        end
      end else if (cnt == '0) begin
        if (bitn == STOP_IDX) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end else begin
          txd   <= shreg[0];
          shreg <= {1'b1, shreg[CHAR_BITS:1]};
          bitn  <= bitn + 1'b1;
          cnt   <= per_q - 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R4

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !txd)); // R2

endmodule

// File: rtl/bsl_uart_rx.sv
module bsl_uart_rx
  import bsl_pkg::*;
#(
  parameter int unsigned PER_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 rx_s,
  input  logic                 rx_fall,
  input  logic [PER_W-1:0]     per,
  output logic                 byte_stb,
  output logic [CHAR_BITS-1:0] byte_val,
  output logic                 stop_ok
);
  localparam int unsigned BIT_W = $clog2(CHAR_BITS);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(CHAR_BITS - 1);

  rx_state_t          st;
  logic [PER_W-1:0]   cnt;
  logic [BIT_W-1:0]   bitn;
  logic [CHAR_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      byte_stb <= 1'b0;
      byte_val <= '0;
      stop_ok  <= 1'b0;
    end else begin
      byte_stb <= 1'b0;
      if (!en) begin
        st <= RX_IDLE;
      end else begin
        unique case (st)
          RX_IDLE: begin
            if (rx_fall) begin
              st  <= RX_START;
              cnt <= (per >> 1) - 1'b1;
            end
          end
          RX_START: begin
            if (cnt == '0) begin
              if (!rx_s) begin
                st   <= RX_DATA;
                bitn <= '0;
                cnt  <= per - 1'b1;
              end else begin
                st <= RX_IDLE;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == '0) begin
              shreg <= {rx_s, shreg[CHAR_BITS-1:1]};
              cnt   <= per - 1'b1;
              if (bitn == LAST_BIT) st <= RX_STOP;
              else                  bitn <= bitn + 1'b1;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == '0) begin
              byte_stb <= 1'b1;
              byte_val <= shreg;
              stop_ok  <= rx_s;
              st       <= RX_IDLE;
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          default: st <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (st == RX_IDLE && !byte_stb)); // R5

endmodule

// File: rtl/boot_serial_loader.sv
module boot_serial_loader
  import bsl_pkg::*;
#(
  parameter int unsigned PER_W         = 16,
  parameter int unsigned MIN_PER       = 4,
  parameter int unsigned PAYLOAD_BYTES = 32,
  parameter int unsigned SYNC_STAGES   = 2,
  localparam int unsigned ADDR_W       = $clog2(PAYLOAD_BYTES),
  localparam int unsigned CNT_W        = $clog2(PAYLOAD_BYTES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 boot_strap_n,
  input  logic                 rxd,
  input  logic [CHAR_BITS-1:0] id_code,
  output logic                 txd,
  output logic                 tx_oe,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [CHAR_BITS-1:0] wr_data,
  output logic                 done,
  output logic                 link_err
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(PAYLOAD_BYTES - 1);
  localparam logic [CNT_W-1:0]  ALL_RCVD  = CNT_W'(PAYLOAD_BYTES);

  seq_state_t           state;
  logic                 boot_sel;
  logic                 rx_s, rx_fall, rx_rise;
  logic                 per_valid;
  logic [PER_W-1:0]     per_meas;
  logic [PER_W-1:0]     per_lock;
  logic                 tx_start, tx_busy, tx_fin;
  logic                 rx_en;
  logic                 byte_stb, stop_ok;
  logic [CHAR_BITS-1:0] byte_val;
  logic [CNT_W-1:0]     rcvd;
  logic                 hs, stall;

  // strap capture: follows the pin only while reset is asserted
  always_ff @(posedge clk) begin
    if (!rst_n) boot_sel <= ~boot_strap_n;
  end

  bsl_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_in   (rxd),
    .rx_s    (rx_s),
    .rx_fall (rx_fall),
    .rx_rise (rx_rise)
  );

  bsl_baud_meter #(.PER_W(PER_W), .MIN_PER(MIN_PER)) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (state == ST_MEASURE),
    .rx_s      (rx_s),
    .rx_fall   (rx_fall),
    .rx_rise   (rx_rise),
    .per_valid (per_valid),
    .per       (per_meas)
  );

  assign tx_start = (state == ST_MEASURE) && per_valid;

  bsl_uart_tx #(.PER_W(PER_W)) u_tx (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tx_start),
    .data  (id_code),
    .per   (per_meas),
    .txd   (txd),
    .busy  (tx_busy),
    .fin   (tx_fin)
  );

  assign rx_en = (state == ST_LOAD) && (rcvd != ALL_RCVD);

  bsl_uart_rx #(.PER_W(PER_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .rx_s     (rx_s),
    .rx_fall  (rx_fall),
    .per      (per_lock),
    .byte_stb (byte_stb),
    .byte_val (byte_val),
    .stop_ok  (stop_ok)
  );

  assign tx_oe = (state == ST_IDENT) || (state == ST_LOAD) || (state == ST_DONE);
  assign hs    = wr_valid && wr_ready;
  assign stall = wr_valid && !wr_ready;

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_ARM;
      per_lock <= '0;
    end else begin
      unique case (state)
        ST_ARM:     state <= boot_sel ? ST_MEASURE : ST_OFF;
        ST_OFF:     state <= ST_OFF;
        ST_MEASURE: if (per_valid) begin
                      state    <= ST_IDENT;
                      per_lock <= per_meas;
                    end
        ST_IDENT:   if (tx_fin) state <= ST_LOAD;
        ST_LOAD:    if (hs && wr_addr == LAST_ADDR) state <= ST_DONE;
        ST_DONE:    state <= ST_DONE;
        default:    state <= ST_OFF;
      endcase
    end
  end

  // write port and payload bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rcvd     <= '0;
      done     <= 1'b0;
      link_err <= 1'b0;
    end else begin
      done <= 1'b0;
      if (hs) begin
        wr_addr <= wr_addr + 1'b1;
        if (wr_addr == LAST_ADDR) done <= 1'b1;
      end
      if (byte_stb && !stall) begin
        wr_valid <= 1'b1;
        wr_data  <= byte_val;
        rcvd     <= rcvd + 1'b1;
      end else if (hs) begin
        wr_valid <= 1'b0;
      end
      if (byte_stb && (!stop_ok || stall)) link_err <= 1'b1;
    end
  end

  AST_QUIET_TX: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> txd); // R4

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_oe |=> tx_oe); // R4

  AST_RX_ONLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |-> (state == ST_LOAD)); // R5

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (wr_valid && $stable(wr_data) && $stable(wr_addr))); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_addr == '0 && state == ST_DONE)); // R8

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    link_err |=> link_err); // R9

  AST_NO_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OFF) |-> (!wr_valid && !tx_oe)); // R1

endmodule

// File: tb/tb_boot_serial_loader.sv
`timescale 1ns/1ps
module tb_boot_serial_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boot_strap_n = 1'b1;
  logic       rxd = 1'b1;
  logic [7:0] id_code = 8'h00;
  logic       txd, tx_oe, wr_valid, done, link_err;
  logic       wr_ready = 1'b1;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;

  always #2.5 clk = ~clk;   // 200 MHz

  boot_serial_loader dut (
    .clk(clk), .rst_n(rst_n), .boot_strap_n(boot_strap_n), .rxd(rxd),
    .id_code(id_code), .txd(txd), .tx_oe(tx_oe), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .link_err(link_err)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cur_p = 16;
  int nwr = 0;
  int done_cnt = 0;
  int id_seen = 0;
  int rdy_mode = 0;
  logic [7:0] exp_q[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ready pattern driver
  int ph = 0;
  always @(posedge clk) begin
    #1;
    ph = (ph + 1) % 3;
    case (rdy_mode)
      0: wr_ready = 1'b1;
      1: wr_ready = (ph == 2);
      default: wr_ready = 1'b0;
    endcase
  end

  // write-port monitor: scoreboard pops, hold rule, done pulse
  logic       prev_stall = 1'b0;
  logic [7:0] held_d;
  logic [4:0] held_a;
  logic       last_was_final = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        done_cnt++;
        check(last_was_final, "R8", "done not right after final transfer", 0, 1);
      end
      if (prev_stall)
        check(wr_valid && wr_data == held_d && wr_addr == held_a, "R7",
              "write port changed while stalled", int'(wr_data), int'(held_d));
      last_was_final = 1'b0;
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "unexpected write", int'(wr_data), -1);
        end else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          check(wr_data == e, "R6", "payload byte", int'(wr_data), int'(e));
          check(int'(wr_addr) == nwr, "R6", "payload address", int'(wr_addr), nwr);
        end
        nwr++;
        last_was_final = (nwr == 32);
      end
      prev_stall = wr_valid && !wr_ready;
      held_d = wr_data;
      held_a = wr_addr;
    end else begin
      prev_stall = 1'b0;
      last_was_final = 1'b0;
    end
  end

  // transmit monitor: decodes the identification byte
  always begin
    @(negedge clk);
    if (rst_n && tx_oe && !txd) begin
      logic [7:0] got;
      logic       st_ok, sp_ok;
      repeat (cur_p / 2) @(negedge clk);
      st_ok = !txd;
      for (int i = 0; i < 8; i++) begin
        repeat (cur_p) @(negedge clk);
        got[i] = txd;
      end
      repeat (cur_p) @(negedge clk);
      sp_ok = txd;
      id_seen++;
      check(st_ok && sp_ok, "R2", "id framing", int'(sp_ok), 1);
      check(got == id_code, "R2", "id byte value", int'(got), int'(id_code));
    end
  end

  task automatic hold_rx(input bit v, input int cycles);
    rxd = v;
    repeat (cycles) @(posedge clk);
    #1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit stop_v, input bit expect_wr);
    if (expect_wr) exp_q.push_back(b);
    hold_rx(1'b0, cur_p);
    for (int i = 0; i < 8; i++) hold_rx(b[i], cur_p);
    hold_rx(stop_v, cur_p);
    rxd = 1'b1;
  endtask

  task automatic do_reset(input bit strap, input int p, input logic [7:0] idv);
    rst_n = 1'b0;
    boot_strap_n = strap;
    rxd = 1'b1;
    rdy_mode = 0;
    cur_p = p;
    id_code = idv;
    exp_q.delete();
    repeat (5) @(posedge clk);
    #1;
    rst_n = 1'b1;
    boot_strap_n = ~strap;   // later strap changes must not matter
    nwr = 0;
    done_cnt = 0;
    id_seen = 0;
    @(negedge clk);
    check(!tx_oe && txd && !wr_valid && !done && !link_err, "R4",
          "reset state", int'({tx_oe, txd, wr_valid, done, link_err}), 8);
    @(posedge clk);
    #1;
  endtask

  task automatic zero_byte();
    hold_rx(1'b0, 9 * cur_p);
    hold_rx(1'b1, 1);
  endtask

  initial begin
    // watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // Scenario 1: strap high, normal start-up
    do_reset(1'b1, 16, 8'h5E);
    zero_byte();
    repeat (20 * cur_p) @(posedge clk);
    send_byte(8'h77, 1'b1, 1'b0);
    repeat (4 * cur_p) @(posedge clk);
    @(negedge clk);
    check(!tx_oe && txd, "R1", "normal mode drives nothing", int'(tx_oe), 0);
    check(nwr == 0 && id_seen == 0, "R1", "normal mode writes", nwr, 0);

    // Scenario 2: loader mode, P=16, full payload
    do_reset(1'b0, 16, 8'hC3);
    repeat (100) @(posedge clk);
    #1;
    hold_rx(1'b0, 27);           // yields period 3: below minimum
    hold_rx(1'b1, 50);
    @(negedge clk);
    check(!tx_oe && id_seen == 0, "R3", "short low pulse rejected", int'(tx_oe), 0);
    @(posedge clk);
    #1;
    zero_byte();
    hold_rx(1'b1, 2 * cur_p);
    @(negedge clk);
    check(tx_oe == 1'b1, "R4", "tx_oe after lock", int'(tx_oe), 1);
    @(posedge clk);
    #1;
    hold_rx(1'b0, 3 * cur_p);    // noise during identification
    hold_rx(1'b1, 8 * cur_p);
    check(id_seen == 1, "R2", "one identification byte", id_seen, 1);
    check(nwr == 0, "R5", "no write from noise during id", nwr, 0);
    rdy_mode = 1;
    for (int i = 0; i < 32; i++) send_byte(8'h5A ^ 8'(i * 37), 1'b1, 1'b1);
    repeat (2 * cur_p) @(posedge clk);
    @(negedge clk);
    check(nwr == 32, "R6", "all payload written", nwr, 32);
    check(done_cnt == 1, "R8", "single done pulse", done_cnt, 1);
    check(!link_err, "R9", "no error on clean load", int'(link_err), 0);
    @(posedge clk);
    #1;
    send_byte(8'hEE, 1'b1, 1'b0);
    repeat (2 * cur_p) @(posedge clk);
    @(negedge clk);
    check(nwr == 32 && done_cnt == 1, "R8", "no write after done", nwr, 32);
    check(tx_oe && txd, "R4", "tx idles high after load", int'(txd), 1);

    // Scenario 3: long idle, P=12, framing error
    do_reset(1'b0, 12, 8'h3C);
    repeat (3000) @(posedge clk);
    #1;
    zero_byte();
    hold_rx(1'b1, 12 * cur_p);
    check(id_seen == 1, "R11", "id after long idle", id_seen, 1);
    send_byte(8'h11, 1'b1, 1'b1);
    repeat (cur_p) @(posedge clk);
    @(negedge clk);
    check(!link_err, "R9", "clean byte no error", int'(link_err), 0);
    @(posedge clk);
    #1;
    send_byte(8'h22, 1'b0, 1'b1);
    hold_rx(1'b1, 2 * cur_p);
    @(negedge clk);
    check(link_err, "R9", "framing error flagged", int'(link_err), 1);
    @(posedge clk);
    #1;
    send_byte(8'h33, 1'b1, 1'b1);
    repeat (2 * cur_p) @(posedge clk);
    @(negedge clk);
    check(link_err, "R9", "error stays set", int'(link_err), 1);
    check(nwr == 3, "R9", "bad-stop byte still delivered", nwr, 3);

    // Scenario 4: overrun under back-pressure, P=10
    do_reset(1'b0, 10, 8'h81);
    repeat (30) @(posedge clk);
    #1;
    zero_byte();
    hold_rx(1'b1, 12 * cur_p);
    rdy_mode = 2;
    send_byte(8'hA1, 1'b1, 1'b1);
    send_byte(8'hB2, 1'b1, 1'b0);
    repeat (cur_p) @(posedge clk);
    @(negedge clk);
    check(link_err, "R10", "overrun flagged", int'(link_err), 1);
    check(wr_valid && wr_data == 8'hA1, "R10", "waiting byte kept", int'(wr_data), 8'hA1);
    check(nwr == 0, "R7", "no transfer while ready low", nwr, 0);
    rdy_mode = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(nwr == 1 && exp_q.size() == 0, "R10", "only first byte written", nwr, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule